// File: doc/BRIEF.md
# Shifter with Carry-Out Flag

This block is the shift stage of a 32-bit integer datapath. It takes one operand, a two-bit shift kind and an eight-bit shift distance. In the same cycle it returns the shifted word and the carry bit that a flag-setting instruction would write. The shift kinds are logical left, logical right and arithmetic right, plus a pass-through code. The distance is eight bits wide, so the block handles distances of 32 and above explicitly. It never wraps them modulo the word width.

The carry rule depends on the shift kind and on where the distance falls. A distance of zero is one case, 1 to 31 is another, exactly 32 is a third, and anything beyond is the last. The right shifts take their out-of-range carry from different places. A logical right shift clears the carry there, while an arithmetic right shift copies the sign bit. A single registered flag sits beside the combinational path. It captures the carry on any clock edge where the set-flags strobe is high, and it feeds back as the carry for the kinds that leave the carry untouched.

Top module: `shift_flag_unit`

## Requirements
- R1: With kind 2'b00 (logical left) and a distance n in 1..31, result is operand shifted left by n with zero fill, and carry_o is operand bit (32-n).
- R2: With kind 2'b00 and distance 32, result is 0 and carry_o is operand bit 0; for distances above 32, result and carry_o are both 0.
- R3: With kind 2'b01 (logical right) and n in 1..31, result is operand shifted right by n with zero fill, and carry_o is operand bit (n-1).
- R4: With kind 2'b01 and a distance of 0 or of 32 and above, carry_o is 0; for 32 and above the result is 0.
- R5: With kind 2'b10 (arithmetic right) and n in 1..31, result is operand shifted right by n, with bit 31 copied into the vacated positions, and carry_o is operand bit (n-1).
- R6: With kind 2'b10 and a distance of 0 or of 32 and above, carry_o is operand bit 31; for 32 and above every result bit equals operand bit 31.
- R7: A distance of 0 returns the operand unchanged for every kind; for kind 2'b00 at distance 0, carry_o equals flag_o.
- R8: Kind 2'b11 passes the operand through for any distance and drives carry_o from flag_o.
- R9: flag_o is 0 after a synchronous reset, loads carry_o on each rising edge where set_flag_i is high, and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| operand_i | input | 32 | Word to be shifted |
| kind_i | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 pass |
| amount_i | input | 8 | Shift distance, 0..255 |
| set_flag_i | input | 1 | Capture carry_o into the flag on this edge |
| result_o | output | 32 | Shifted word (combinational) |
| carry_o | output | 1 | Carry that a flag update would take (combinational) |
| flag_o | output | 1 | Registered carry flag |

## Verification
The properties assume that every input is a known value from the first clock edge after reset, since the combinational result and carry checks are sampled on each edge. They also assume that set_flag_i is meaningful only while rst is low. The bench holds rst high from time zero and drives all inputs to defined values before the first edge. It changes inputs only one time unit after a rising edge, so each edge samples a settled operand, kind and distance.

// File: rtl/shift_pkg.sv
package shift_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned DIST_W = 8;

    typedef enum logic [1:0] {
        SK_LSL  = 2'b00,
        SK_LSR  = 2'b01,
        SK_ASR  = 2'b10,
        SK_PASS = 2'b11
    } shift_kind_e;

    // Where a distance falls relative to the word width
    typedef enum logic [1:0] {
        DR_ZERO   = 2'b00,
        DR_INSIDE = 2'b01,
        DR_EXACT  = 2'b10,
        DR_BEYOND = 2'b11
    } dist_range_e;

    function automatic logic moves_right(shift_kind_e k);
        return (k == SK_LSR) || (k == SK_ASR);
    endfunction

endpackage

// File: rtl/shift_dist_class.sv
module shift_dist_class
    import shift_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned AMT_W  = DIST_W,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic [AMT_W-1:0] dist_i,
    output dist_range_e      range_o,
    output logic [SH_W-1:0]  low_o
);
    logic [AMT_W-SH_W-1:0] upper;

    assign upper = dist_i[AMT_W-1:SH_W];
    assign low_o = dist_i[SH_W-1:0];

    always_comb begin
        if (dist_i == '0)
            range_o = DR_ZERO;
        else if (upper == '0)
            range_o = DR_INSIDE;
        else if (dist_i == AMT_W'(DATA_W))
            range_o = DR_EXACT;
        else
            range_o = DR_BEYOND;
    end

endmodule

// File: rtl/shift_barrel.sv
module shift_barrel #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [SH_W-1:0]   dist_i,
    input  logic              left_i,
    input  logic              fill_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] flipped_in;
    logic [DATA_W-1:0] flipped_out;
    logic [DATA_W-1:0] stage [SH_W+1];

    // Left shifts reuse the right-shift network on a bit-reversed word
    for (genvar i = 0; i < DATA_W; i++) begin : g_flip
        assign flipped_in[i]  = data_i[DATA_W-1-i];
        assign flipped_out[i] = stage[SH_W][DATA_W-1-i];
    end

    assign stage[0] = left_i ? flipped_in : data_i;

    for (genvar g = 0; g < SH_W; g++) begin : g_stage
        localparam int unsigned SPAN = 1 << g;
        assign stage[g+1] = dist_i[g]
            ? {{SPAN{fill_i}}, stage[g][DATA_W-1:SPAN]}
            : stage[g];
    end

    assign data_o = left_i ? flipped_out : stage[SH_W];

endmodule

// File: rtl/shift_carry_pick.sv
module shift_carry_pick
    import shift_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  shift_kind_e       kind_i,
    input  dist_range_e       range_i,
    input  logic [SH_W-1:0]   low_i,
    input  logic              flag_i,
    output logic              carry_o
);
    logic [SH_W-1:0] idx_left;
    logic [SH_W-1:0] idx_right;

    // Last bit shifted out: width-n for left, n-1 for right
    assign idx_left  = '0 - low_i;
    assign idx_right = low_i - 1'b1;

    always_comb begin
        carry_o = flag_i;
        unique case (kind_i)
            SK_LSL: begin
                unique case (range_i)
                    DR_ZERO:   carry_o = flag_i;
                    DR_INSIDE: carry_o = data_i[idx_left];
                    DR_EXACT:  carry_o = data_i[0];
                    DR_BEYOND: carry_o = 1'b0;
                    default:   carry_o = 1'b0;
                endcase
            end
            SK_LSR: carry_o = (range_i == DR_INSIDE) ? data_i[idx_right] : 1'b0;
            SK_ASR: carry_o = (range_i == DR_INSIDE) ? data_i[idx_right]
                                                     : data_i[DATA_W-1];
            SK_PASS: carry_o = flag_i;
            default: carry_o = flag_i;
        endcase
    end

endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
    import shift_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned AMT_W  = DIST_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [1:0]        kind_i,
    input  logic [AMT_W-1:0]  amount_i,
    input  logic              set_flag_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              flag_o
);
    localparam int unsigned SH_W = $clog2(DATA_W);

    shift_kind_e       kind;
    dist_range_e       range;
    logic [SH_W-1:0]   low;
    logic              fill;
    logic [DATA_W-1:0] shifted;
    logic              carry;
    logic              flag_q;

    assign kind = shift_kind_e'(kind_i);
    assign fill = (kind == SK_ASR) & operand_i[DATA_W-1];

    shift_dist_class #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_class (
        .dist_i  (amount_i),
        .range_o (range),
        .low_o   (low)
    );

    shift_barrel #(.DATA_W(DATA_W)) u_barrel (
        .data_i (operand_i),
        .dist_i (low),
        .left_i (kind == SK_LSL),
        .fill_i (fill),
        .data_o (shifted)
    );

    shift_carry_pick #(.DATA_W(DATA_W)) u_carry (
        .data_i  (operand_i),
        .kind_i  (kind),
        .range_i (range),
        .low_i   (low),
        .flag_i  (flag_q),
        .carry_o (carry)
    );

    always_comb begin
        if (kind == SK_PASS || range == DR_ZERO)
            result_o = operand_i;
        else if (range == DR_INSIDE)
            result_o = shifted;
        else
            result_o = moves_right(kind) ? {DATA_W{fill}} : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (set_flag_i)
            flag_q <= carry;
    end

    assign carry_o = carry;
    assign flag_o  = flag_q;

endmodule

// File: rtl/shift_flag_unit_chk.sv
module shift_flag_unit_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned AMT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] operand_i,
    input logic [1:0]        kind_i,
    input logic [AMT_W-1:0]  amount_i,
    input logic              set_flag_i,
    input logic [DATA_W-1:0] result_o,
    input logic              carry_o,
    input logic              flag_o
);
    logic over;
    assign over = (amount_i >= AMT_W'(DATA_W));

    a_r9_flag_hold: assert property (@(posedge clk) disable iff (rst)
        !set_flag_i |=> $stable(flag_o));

    a_r9_flag_load: assert property (@(posedge clk) disable iff (rst)
        set_flag_i |=> (flag_o == $past(carry_o)));

    a_r2_left_over_zero: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 2'b00 && amount_i > AMT_W'(DATA_W)) |-> (result_o == '0 && !carry_o));

    a_r4_lsr_out_carry: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 2'b01 && (amount_i == '0 || over)) |-> !carry_o);

    a_r6_asr_out_sign: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 2'b10 && over) |->
            (carry_o == operand_i[DATA_W-1] && result_o == {DATA_W{operand_i[DATA_W-1]}}));

    a_r7_zero_dist: assert property (@(posedge clk) disable iff (rst)
        (amount_i == '0) |-> (result_o == operand_i));

    a_r8_pass: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 2'b11) |-> (result_o == operand_i && carry_o == flag_o));

endmodule

bind shift_flag_unit shift_flag_unit_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .operand_i  (operand_i),
    .kind_i     (kind_i),
    .amount_i   (amount_i),
    .set_flag_i (set_flag_i),
    .result_o   (result_o),
    .carry_o    (carry_o),
    .flag_o     (flag_o)
);

// File: tb/shift_flag_unit_bench.sv
module shift_flag_unit_bench;

    localparam int CLK_P = 10;

    typedef struct packed {
        logic [15:0] tag;
        logic [31:0] op;
        logic [1:0]  kind;
        logic [7:0]  amt;
        logic [31:0] res;
        logic        c;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{"R1", 32'h8000_0001, 2'b00, 8'd1,   32'h0000_0002, 1'b1},
        '{"R1", 32'h8000_0001, 2'b00, 8'd31,  32'h8000_0000, 1'b0},
        '{"R1", 32'h0000_0003, 2'b00, 8'd31,  32'h8000_0000, 1'b1},
        '{"R1", 32'h0000_00F0, 2'b00, 8'd4,   32'h0000_0F00, 1'b0},
        '{"R2", 32'h0000_0001, 2'b00, 8'd32,  32'h0000_0000, 1'b1},
        '{"R2", 32'hFFFF_FFFF, 2'b00, 8'd33,  32'h0000_0000, 1'b0},
        '{"R2", 32'hFFFF_FFFF, 2'b00, 8'd200, 32'h0000_0000, 1'b0},
        '{"R3", 32'h8000_0010, 2'b01, 8'd5,   32'h0400_0000, 1'b1},
        '{"R3", 32'h8000_0010, 2'b01, 8'd4,   32'h0800_0001, 1'b0},
        '{"R3", 32'h8000_0000, 2'b01, 8'd31,  32'h0000_0001, 1'b0},
        '{"R4", 32'hFFFF_FFFF, 2'b01, 8'd32,  32'h0000_0000, 1'b0},
        '{"R4", 32'hFFFF_FFFF, 2'b01, 8'd255, 32'h0000_0000, 1'b0},
        '{"R4", 32'h1234_5678, 2'b01, 8'd0,   32'h1234_5678, 1'b0},
        '{"R5", 32'h8000_0010, 2'b10, 8'd5,   32'hFC00_0000, 1'b1},
        '{"R5", 32'h7000_0001, 2'b10, 8'd1,   32'h3800_0000, 1'b1},
        '{"R5", 32'h8000_0000, 2'b10, 8'd31,  32'hFFFF_FFFF, 1'b0},
        '{"R6", 32'h8000_0000, 2'b10, 8'd32,  32'hFFFF_FFFF, 1'b1},
        '{"R6", 32'h7FFF_FFFF, 2'b10, 8'd64,  32'h0000_0000, 1'b0},
        '{"R6", 32'h8765_4321, 2'b10, 8'd0,   32'h8765_4321, 1'b1},
        '{"R6", 32'h7FFF_FFFF, 2'b10, 8'd0,   32'h7FFF_FFFF, 1'b0},
        '{"R7", 32'hDEAD_BEEF, 2'b00, 8'd0,   32'hDEAD_BEEF, 1'b0},
        '{"R8", 32'hDEAD_BEEF, 2'b11, 8'd17,  32'hDEAD_BEEF, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] operand_i = '0;
    logic [1:0]  kind_i = 2'b00;
    logic [7:0]  amount_i = '0;
    logic        set_flag_i = 1'b0;
    logic [31:0] result_o;
    logic        carry_o;
    logic        flag_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_P/2) clk = ~clk;

    shift_flag_unit u_shift_flag_unit (
        .clk        (clk),
        .rst        (rst),
        .operand_i  (operand_i),
        .kind_i     (kind_i),
        .amount_i   (amount_i),
        .set_flag_i (set_flag_i),
        .result_o   (result_o),
        .carry_o    (carry_o),
        .flag_o     (flag_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] op, input logic [1:0] k,
                         input logic [7:0] a, input logic sf);
        operand_i  = op;
        kind_i     = k;
        amount_i   = a;
        set_flag_i = sf;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        tick();
        tick();
        rst = 1'b0;
        check("R9", "flag after reset", 32'(flag_o), 32'd0);

        // Table walk with the flag held at 0
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].kind, VECS[i].amt, 1'b0);
            #1;
            check(string'(VECS[i].tag), "result", result_o, VECS[i].res);
            check(string'(VECS[i].tag), "carry", 32'(carry_o), 32'(VECS[i].c));
            tick();
        end

        // R9: capture a carry of 1
        drive(32'h8000_0001, 2'b00, 8'd1, 1'b1);
        tick();
        check("R9", "flag load 1", 32'(flag_o), 32'd1);

        // R9: hold while strobe low, carry of 0 presented
        drive(32'hFFFF_FFFF, 2'b01, 8'd40, 1'b0);
        tick();
        tick();
        check("R9", "flag hold", 32'(flag_o), 32'd1);

        // R7: left shift by zero reports the flag as carry
        drive(32'h0F0F_0F0F, 2'b00, 8'd0, 1'b0);
        #1;
        check("R7", "lsl0 result", result_o, 32'h0F0F_0F0F);
        check("R7", "lsl0 carry", 32'(carry_o), 32'd1);

        // R8: pass-through carries the flag, any distance
        drive(32'h0000_0000, 2'b11, 8'd255, 1'b0);
        #1;
        check("R8", "pass result", result_o, 32'h0000_0000);
        check("R8", "pass carry", 32'(carry_o), 32'd1);

        // R9: capture a carry of 0 from an out-of-range logical right shift
        drive(32'hFFFF_FFFF, 2'b01, 8'd32, 1'b1);
        tick();
        check("R9", "flag load 0", 32'(flag_o), 32'd0);

        // R9: load 1 again, then synchronous reset clears it
        drive(32'h8000_0000, 2'b10, 8'd100, 1'b1);
        tick();
        check("R9", "flag load asr", 32'(flag_o), 32'd1);
        set_flag_i = 1'b0;
        rst = 1'b1;
        tick();
        check("R9", "flag after second reset", 32'(flag_o), 32'd0);
        rst = 1'b0;
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule